// File: doc/BRIEF.md
# Raster Timing and Border Generator

This block produces the raster timing for a display controller. A horizontal counter and a line counter run up to programmed totals and mark out a sync region, a border region framed by separate start and stop positions on each axis, and a display window placed inside it. For each pixel position the block reports whether the pixel comes from the image or from the border colour. Progressive, interlaced, scan-doubled and full-rate pixel clock operation are selected from a control word. A blank bit stretches the border over the whole frame and leaves the sync pulses running.

Software writes the registers over a simple write-only bus. Every write lands in a shadow copy. The whole shadow set is copied into the working set on the step that wraps the frame back to its origin. That is the first clock of vertical sync, and a one-cycle frame interrupt pulse is raised in the same cycle. A mode change or pan therefore never tears a frame. After reset the working set is all zero, so the generator runs a one-pixel frame, and the first programmed configuration takes effect within a few clocks.

Top module: `vid_raster_gen`

## Requirements
- R1: Writes go to shadow registers and reach the working set only at the frame wrap, so a value written mid-frame has no effect until the next frame. A write on the same edge as the wrap takes effect one frame later. The register addresses are as follows. Address 0 is the totals: lines in [25:16] and clocks in [9:0]. Address 1 is the horizontal border: start in [25:16] and stop in [9:0]. Address 2 is the vertical border, with the same layout. Address 3 is the horizontal window: start in [25:16] and width in [9:0]. Address 4 is the vertical window start: long-field start in [25:16] and short-field start in [9:0]. Address 5 is the window height in [9:0]. Address 6 is the control word.
- R2: `hCount` runs from 0 up to the clock total and then wraps, which advances `vCount`. `vCount` runs from 0 up to the line total. A frame lasts (clocks+1)*(lines+1) pixel steps.
- R3: With control bit 23 set, a pixel step happens on every clock. With it clear, a step happens on every second clock and the counters hold in between.
- R4: `hSync` is high while `hCount` is below the horizontal border start. `vSync` is high while `vCount` is below the vertical border start.
- R5: `borderOn` is high when both counters lie in the half-open range from the border start to the border stop of their axis.
- R6: `pixelOn` is high inside the border, inside the window columns [start, start+width) and inside the window rows [rowStart, rowStart+height). It also requires control bit 0 (display enable) and control bit 8 (video enable) to be set.
- R7: With control bit 3 set, `borderOn` is high over the whole frame and `pixelOn` is low.
- R8: With control bit 4 set (interlace), `field` toggles at every frame wrap and is held at 0 otherwise. Field 0 uses the long-field start as the window row start, and field 1 uses the short-field start.
- R9: `winLine` gives the row offset within the window, halved when control bit 1 (scan doubling) is set, so each source line is output twice. It is 0 outside the window rows.
- R10: `frameIrq` is high for exactly the first clock of each frame, with both counters at 0.
- R11: During reset both counters, `frameIrq`, `field`, `borderOn` and `pixelOn` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| pixEn | output | 1 | Pixel step enable |
| hCount | output | 10 | Horizontal position |
| vCount | output | 10 | Line position |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| borderOn | output | 1 | Inside the border region or blanked |
| pixelOn | output | 1 | Image pixel selected, else border colour |
| winLine | output | 10 | Source row within the window |
| field | output | 1 | Current interlace field |
| frameIrq | output | 1 | One-cycle pulse at frame start |

## Verification
A bus write and the shadow-to-working copy can fall on the same clock edge. The bench provokes this by waiting at the last pixel of a frame and issuing the write to set the blank bit in that cycle, so that it lands on the wrapping edge. The check expects the frame that follows to be unblanked, because the copy took the old shadow value, and the frame after it to be fully border. A further check writes mid-frame and confirms the output stays unchanged until the next frame interrupt.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  // register addresses
  localparam int REG_TOTALS = 0;
  localparam int REG_HBORD  = 1;
  localparam int REG_VBORD  = 2;
  localparam int REG_HWIN   = 3;
  localparam int REG_VWIN   = 4;
  localparam int REG_WINHT  = 5;
  localparam int REG_CTRL   = 6;
  localparam int NUM_REGS   = 7;
  // control word bit positions
  localparam int CB_DISP  = 0;
  localparam int CB_SDBL  = 1;
  localparam int CB_BLANK = 3;
  localparam int CB_INTL  = 4;
  localparam int CB_VIDEO = 8;
  localparam int CB_CDBL  = 23;
  // upper field base of a packed register
  localparam int HI_BASE  = 16;

  typedef struct packed {
    logic pixEn;
    logic lineEnd;
    logic frameEnd;
  } vrgStrobe_t;
endpackage

// File: rtl/vrg_ctrl.sv
module vrg_ctrl
  import vrg_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] hTotal,
  input  logic [CW-1:0] vTotal,
  input  logic          clkDbl,
  output logic [CW-1:0] hCnt,
  output logic [CW-1:0] vCnt,
  output vrgStrobe_t    stb
);
  logic phase;

  always_comb begin
    stb.pixEn    = clkDbl | phase;
    stb.lineEnd  = stb.pixEn && (hCnt == hTotal);
    stb.frameEnd = stb.lineEnd && (vCnt == vTotal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0;
      hCnt  <= '0;
      vCnt  <= '0;
    end else begin
      phase <= ~phase;
      if (stb.pixEn) begin
        if (stb.lineEnd) begin
          hCnt <= '0;
          vCnt <= stb.frameEnd ? '0 : vCnt + 1'b1;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vrg_path.sv
module vrg_path
  import vrg_pkg::*;
#(
  parameter int CW = 10,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  vrgStrobe_t    stb,
  input  logic [CW-1:0] hCnt,
  input  logic [CW-1:0] vCnt,
  output logic [CW-1:0] hTotal,
  output logic [CW-1:0] vTotal,
  output logic          clkDbl,
  output logic          intlOn,
  output logic          hSync,
  output logic          vSync,
  output logic          borderOn,
  output logic          pixelOn,
  output logic [CW-1:0] winLine,
  output logic          field,
  output logic          frameIrq
);
  logic [NUM_REGS-1:0][DW-1:0] shadowR;
  logic [NUM_REGS-1:0][DW-1:0] actR;
  logic unusedBits;
  assign unusedBits = ^actR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowR  <= '0;
      actR     <= '0;
      field    <= 1'b0;
      frameIrq <= 1'b0;
    end else begin
      if (wrEn && (int'(wrAddr) < NUM_REGS)) shadowR[wrAddr] <= wrData;
      frameIrq <= stb.frameEnd;
      if (stb.frameEnd) begin
        actR  <= shadowR;
        field <= shadowR[REG_CTRL][CB_INTL] ? ~field : 1'b0;
      end
    end
  end

  logic [CW-1:0] hBs, hBe, vBs, vBe, hWs, hWw, vWl, vWsh, vWh, vWs, rowOff;
  logic [DW-1:0] ctrl;
  logic inBorder, inCols, inRows;

  always_comb begin
    hTotal = actR[REG_TOTALS][CW-1:0];
    vTotal = actR[REG_TOTALS][HI_BASE +: CW];
    hBs    = actR[REG_HBORD][HI_BASE +: CW];
    hBe    = actR[REG_HBORD][CW-1:0];
    vBs    = actR[REG_VBORD][HI_BASE +: CW];
    vBe    = actR[REG_VBORD][CW-1:0];
    hWs    = actR[REG_HWIN][HI_BASE +: CW];
    hWw    = actR[REG_HWIN][CW-1:0];
    vWl    = actR[REG_VWIN][HI_BASE +: CW];
    vWsh   = actR[REG_VWIN][CW-1:0];
    vWh    = actR[REG_WINHT][CW-1:0];
    ctrl   = actR[REG_CTRL];
    clkDbl = ctrl[CB_CDBL];
    intlOn = ctrl[CB_INTL];

    vWs    = (intlOn && field) ? vWsh : vWl;
    rowOff = vCnt - vWs;

    hSync    = hCnt < hBs;
    vSync    = vCnt < vBs;
    inBorder = (hCnt >= hBs) && (hCnt < hBe) && (vCnt >= vBs) && (vCnt < vBe);
    inCols   = (hCnt >= hWs) && ((hCnt - hWs) < hWw);
    inRows   = (vCnt >= vWs) && (rowOff < vWh);

    borderOn = ctrl[CB_BLANK] | inBorder;
    pixelOn  = ~ctrl[CB_BLANK] & ctrl[CB_DISP] & ctrl[CB_VIDEO] &
               inBorder & inCols & inRows;
    if (!inRows)             winLine = '0;
    else if (ctrl[CB_SDBL])  winLine = rowOff >> 1;
    else                     winLine = rowOff;
  end
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
  import vrg_pkg::*;
#(
  parameter int CW = 10,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          pixEn,
  output logic [CW-1:0] hCount,
  output logic [CW-1:0] vCount,
  output logic          hSync,
  output logic          vSync,
  output logic          borderOn,
  output logic          pixelOn,
  output logic [CW-1:0] winLine,
  output logic          field,
  output logic          frameIrq
);
  vrgStrobe_t    stb;
  logic [CW-1:0] hTotal, vTotal;
  logic          clkDbl, intlOn;

  vrg_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hTotal(hTotal), .vTotal(vTotal),
    .clkDbl(clkDbl), .hCnt(hCount), .vCnt(vCount), .stb(stb)
  );

  vrg_path #(.CW(CW), .AW(AW), .DW(DW)) u_path (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .hCnt(hCount), .vCnt(vCount), .hTotal(hTotal),
    .vTotal(vTotal), .clkDbl(clkDbl), .intlOn(intlOn), .hSync(hSync),
    .vSync(vSync), .borderOn(borderOn), .pixelOn(pixelOn),
    .winLine(winLine), .field(field), .frameIrq(frameIrq)
  );

  assign pixEn = stb.pixEn;
endmodule

// File: rtl/vrg_checker.sv
module vrg_checker #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixEn,
  input logic [CW-1:0] hCount,
  input logic [CW-1:0] vCount,
  input logic          hSync,
  input logic          vSync,
  input logic          borderOn,
  input logic          pixelOn,
  input logic          field,
  input logic          frameIrq,
  input logic [CW-1:0] actHTotal,
  input logic          actIntl
);
  a_r10_irq_at_origin: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> (hCount == '0 && vCount == '0));

  a_r6_window_inside_border: assert property (@(posedge clk) disable iff (!rstN)
    pixelOn |-> (borderOn && !hSync && !vSync));

  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(hCount) && $stable(vCount)));

  a_r2_h_within_total: assert property (@(posedge clk) disable iff (!rstN)
    hCount <= actHTotal);

  a_r8_field_low_progressive: assert property (@(posedge clk) disable iff (!rstN)
    !actIntl |-> !field);
endmodule

bind vid_raster_gen vrg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .hCount(hCount), .vCount(vCount),
  .hSync(hSync), .vSync(vSync), .borderOn(borderOn), .pixelOn(pixelOn),
  .field(field), .frameIrq(frameIrq), .actHTotal(hTotal), .actIntl(intlOn)
);

// File: tb/sim_vid_raster_gen.sv
`timescale 1ns/1ps
module sim_vid_raster_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic pixEn, hSync, vSync, borderOn, pixelOn, field, frameIrq;
  logic [9:0] hCount, vCount, winLine;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_raster_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixEn(pixEn), .hCount(hCount), .vCount(vCount), .hSync(hSync),
    .vSync(vSync), .borderOn(borderOn), .pixelOn(pixelOn),
    .winLine(winLine), .field(field), .frameIrq(frameIrq)
  );

  localparam logic [31:0] CTRL_BASE = 32'h0080_0101; // full-rate, video, display

  // {h, v, hSync, vSync, borderOn, pixelOn, winLine} for the base config
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {10'd0,  10'd0,  1'b1, 1'b1, 1'b0, 1'b0, 10'd0},
    {10'd3,  10'd5,  1'b1, 1'b0, 1'b0, 1'b0, 10'd2},
    {10'd4,  10'd5,  1'b0, 1'b0, 1'b1, 1'b0, 10'd2},
    {10'd5,  10'd5,  1'b0, 1'b0, 1'b1, 1'b0, 10'd2},
    {10'd6,  10'd5,  1'b0, 1'b0, 1'b1, 1'b1, 10'd2},
    {10'd13, 10'd5,  1'b0, 1'b0, 1'b1, 1'b1, 10'd2},
    {10'd14, 10'd5,  1'b0, 1'b0, 1'b1, 1'b0, 10'd2},
    {10'd17, 10'd5,  1'b0, 1'b0, 1'b1, 1'b0, 10'd2},
    {10'd18, 10'd5,  1'b0, 1'b0, 1'b0, 1'b0, 10'd2},
    {10'd6,  10'd1,  1'b0, 1'b1, 1'b0, 1'b0, 10'd0},
    {10'd6,  10'd2,  1'b0, 1'b0, 1'b1, 1'b0, 10'd0},
    {10'd6,  10'd3,  1'b0, 1'b0, 1'b1, 1'b1, 10'd0},
    {10'd6,  10'd7,  1'b0, 1'b0, 1'b1, 1'b1, 10'd4},
    {10'd6,  10'd8,  1'b0, 1'b0, 1'b1, 1'b0, 10'd0},
    {10'd6,  10'd11, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, hCount, vCount);
    end
  endtask

  task automatic wrNow(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrNow(a, d);
  endtask

  task automatic waitPos(input int h, input int v);
    do @(negedge clk); while (!(hCount == h && vCount == v));
  endtask

  task automatic waitIrq();
    do @(negedge clk); while (!frameIrq);
  endtask

  task automatic framePeriod(input string tag, input int exp);
    int n = 0;
    waitIrq();
    @(negedge clk);
    chk({tag, " R10 pulse width"}, frameIrq, 0);
    n = 1;
    while (!frameIrq) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R2 frame length"}, n, exp);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 hCount", hCount, 0);
    chk("R11 vCount", vCount, 0);
    chk("R11 frameIrq", frameIrq, 0);
    chk("R11 pixelOn", pixelOn, 0);
    chk("R11 borderOn", borderOn, 0);
    chk("R11 field", field, 0);
    rstN = 1'b1;

    // base configuration: 20 clocks x 12 lines
    wr(3'd0, 32'h000B_0013);
    wr(3'd1, 32'h0004_0012);
    wr(3'd2, 32'h0002_000B);
    wr(3'd3, 32'h0006_0008);
    wr(3'd4, 32'h0003_0004);
    wr(3'd5, 32'h0000_0005);
    wr(3'd6, CTRL_BASE);
    waitIrq();

    // vector table: R4 R5 R6 R9 positions
    for (int i = 0; i < NV; i++) begin
      waitPos(int'(VEC[i][33:24]), int'(VEC[i][23:14]));
      chk("R4 hSync", hSync, int'(VEC[i][13]));
      chk("R4 vSync", vSync, int'(VEC[i][12]));
      chk("R5 borderOn", borderOn, int'(VEC[i][11]));
      chk("R6 pixelOn", pixelOn, int'(VEC[i][10]));
      chk("R9 winLine", winLine, int'(VEC[i][9:0]));
    end

    // R3 R2 R10 full-rate frame length and irq at origin
    framePeriod("R3 full rate", 240);
    chk("R10 irq h", hCount, 0);
    chk("R10 irq v", vCount, 0);

    // R1 mid-frame write held off until next frame (display enable off)
    waitPos(6, 5);
    wrNow(3'd6, 32'h0080_0100);
    waitPos(6, 7);
    chk("R1 mid-frame write not yet live", pixelOn, 1);
    waitIrq();
    waitPos(6, 5);
    chk("R6 display disabled pixelOn", pixelOn, 0);
    chk("R6 display disabled borderOn", borderOn, 1);
    wr(3'd6, 32'h0080_0001);
    waitIrq();
    waitPos(6, 5);
    chk("R6 video disabled pixelOn", pixelOn, 0);
    wr(3'd6, CTRL_BASE);
    waitIrq();
    waitPos(6, 5);
    chk("R6 restored pixelOn", pixelOn, 1);

    // R1 R7 write on the wrap edge: lands one frame later
    waitPos(19, 11);
    wrNow(3'd6, CTRL_BASE | 32'h8);
    chk("R1 wrap-edge write irq", frameIrq, 1);
    waitPos(6, 5);
    chk("R1 wrap-edge write not in this frame", pixelOn, 1);
    waitIrq();
    chk("R7 blank border at origin", borderOn, 1);
    chk("R7 blank keeps hSync", hSync, 1);
    waitPos(6, 5);
    chk("R7 blank pixelOn", pixelOn, 0);
    chk("R7 blank borderOn", borderOn, 1);
    waitPos(19, 11);
    chk("R7 blank border outside frame edge", borderOn, 1);
    wr(3'd6, CTRL_BASE);
    waitIrq();

    // R9 scan doubling
    wr(3'd6, CTRL_BASE | 32'h2);
    waitIrq();
    waitPos(6, 3); chk("R9 sdbl line v3", winLine, 0);
    waitPos(6, 4); chk("R9 sdbl line v4", winLine, 0);
    waitPos(6, 5); chk("R9 sdbl line v5", winLine, 1);
    waitPos(6, 7); chk("R9 sdbl line v7", winLine, 2);

    // R8 interlace: first interlaced field is 1 (short start 4)
    wr(3'd6, CTRL_BASE | 32'h10);
    waitIrq();
    chk("R8 field after load", field, 1);
    waitPos(6, 3); chk("R8 short field row3", pixelOn, 0);
    waitPos(6, 4); chk("R8 short field row4", pixelOn, 1);
    waitPos(6, 8); chk("R8 short field row8", pixelOn, 1);
    waitPos(6, 9); chk("R8 short field row9", pixelOn, 0);
    waitIrq();
    chk("R8 field toggles", field, 0);
    waitPos(6, 3); chk("R8 long field row3", pixelOn, 1);
    waitPos(6, 8); chk("R8 long field row8", pixelOn, 0);
    wr(3'd6, CTRL_BASE);
    waitIrq();
    chk("R8 progressive field", field, 0);
    waitIrq();
    chk("R8 progressive field held", field, 0);

    // R3 half-rate pixel step
    wr(3'd6, 32'h0000_0101);
    waitIrq();
    framePeriod("R3 half rate", 480);
    @(negedge clk);
    chk("R3 half rate hold", hCount, 0);
    @(negedge clk);
    chk("R3 half rate step", hCount, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule